// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the serial clock of an I2C master from the peripheral clock. A single programmed count sets the bus rate. A mode input selects standard or fast timing. In fast timing a duty input selects one of two low-to-high ratios. The block asks for SCL to be driven low while in the low phase and releases the line for the high phase. The high phase is counted only once the line is sensed high, so a slave that holds SCL low stretches the clock. A rise-time limit bounds how long the block waits for the line before it counts the high phase anyway.

Two one-cycle strobes pace a separate bit engine. One fires in the middle of each counted high phase, where SDA is sampled. The other fires in the first cycle of each low phase, where SDA may change. Register decoding, START/STOP sequencing, data shifting and arbitration sit outside this block.

Top module: `scl_clkgen`

## Requirements
- R1: With `fast_mode`=0, every low phase and every counted high phase lasts N peripheral clock cycles, where N is the effective count.
- R2: With `fast_mode`=1 and `duty_169`=0, the low phase lasts 2N cycles and the counted high phase lasts N cycles.
- R3: With `fast_mode`=1 and `duty_169`=1, the low phase lasts 16N cycles and the counted high phase lasts 9N cycles.
- R4: The effective count N equals `ccr_count`, with a minimum of 4 in standard mode and a minimum of 1 in fast mode. Smaller programmed values are raised to that minimum.
- R5: The effective wait limit equals `rise_limit`, but a programmed 0 or 1 is raised to 2. The field is 6 bits, so its maximum is 63.
- R6: After release, the high count starts on the first cycle `scl_sense` is 1, or after W cycles of the line sensed low, whichever comes first. W is the effective wait limit, so one period lasts low + min(stretch, W) + high cycles.
- R7: During reset, and from the cycle after `en` is sampled 0, `scl_pull_low` and both strobes are 0 and all phase counting restarts.
- R8: `strobe_fall` is 1 for exactly one cycle, in the first cycle of each low phase. That includes the first low phase after enable.
- R9: `strobe_mid_high` is 1 exactly once per high phase, on counted high cycle floor(H/2), where H is the high length and cycles are numbered from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Clock generation enable |
| fast_mode | input | 1 | 0 = standard timing, 1 = fast timing |
| duty_169 | input | 1 | In fast timing: 0 = 2:1, 1 = 16:9 low-to-high |
| ccr_count | input | CNT_W | Programmed clock-control count |
| rise_limit | input | RT_W | Longest wait for the line to rise, in cycles |
| scl_sense | input | 1 | Sensed SCL line level |
| scl_pull_low | output | 1 | Request to drive SCL low |
| strobe_mid_high | output | 1 | One-cycle pulse in the middle of the high phase |
| strobe_fall | output | 1 | One-cycle pulse at each SCL falling edge |

## Verification
Each timing formula is run with small counts and with counts below the minimums. This checks the 1:1, 2:1 and 16:9 lengths and the clamps that raise a count to 4 or to 1. A line model holds SCL low for a chosen number of cycles after release. When the hold is shorter than the limit, the period grows by exactly the hold. When it is longer, the period grows by the limit, and rise limits of 0 and 1 show the floor of 2. Random counts, modes, limits and holds then mix all of these cases. Periods of disable and reset check that the line is released and no strobe fires.

// File: rtl/scl_gen_pkg.sv
// Shared types for the SCL clock generator.
package scl_gen_pkg;
    // Phase of the generated clock.
    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_t;
endpackage

// File: rtl/scl_phase_len.sv
// Turns the programmed count, mode and duty select into phase lengths.
// Assumes: PH_W is wide enough to hold 16 times the largest count.
module scl_phase_len #(
    parameter int CNT_W = 12,
    parameter int PH_W  = CNT_W + 4
) (
    input  logic             fast_mode,
    input  logic             duty_169,
    input  logic [CNT_W-1:0] ccr_count,
    output logic [PH_W-1:0]  low_len,
    output logic [PH_W-1:0]  high_len,
    output logic [PH_W-1:0]  half_high
);
    localparam int STD_MIN  = 4;
    localparam int FAST_MIN = 1;

    logic [PH_W-1:0] n_eff;

    // Raise the count to the minimum that the selected mode allows.
    always_comb begin
        n_eff = PH_W'(ccr_count);
        if (fast_mode) begin
            if (ccr_count < CNT_W'(FAST_MIN)) n_eff = PH_W'(FAST_MIN);
        end else begin
            if (ccr_count < CNT_W'(STD_MIN)) n_eff = PH_W'(STD_MIN);
        end
    end

    // Choose the low and high lengths that match the selected ratio.
    always_comb begin
        if (!fast_mode) begin
            low_len  = n_eff;
            high_len = n_eff;
        end else if (!duty_169) begin
            low_len  = n_eff << 1;
            high_len = n_eff;
        end else begin
            low_len  = n_eff << 4;
            high_len = (n_eff << 3) + n_eff;
        end
        half_high = high_len >> 1;
    end
endmodule

// File: rtl/scl_rise_limit.sv
// Clamps the rise-time wait limit to its legal floor.
// Assumes: the field width itself bounds the maximum.
module scl_rise_limit #(
    parameter int RT_W = 6
) (
    input  logic [RT_W-1:0] rise_raw,
    output logic [RT_W-1:0] rise_lim
);
    localparam int RT_FLOOR = 2;

    // Raise values under the floor to the floor.
    always_comb begin
        rise_lim = (rise_raw < RT_W'(RT_FLOOR)) ? RT_W'(RT_FLOOR) : rise_raw;
    end
endmodule

// File: rtl/scl_phase_ctrl.sv
// Phase sequencer: counts low phases, waits for the line to rise and
// counts high phases, then raises the strobes for the bit engine.
// Assumes: the lengths are at least 1 and stay stable while enabled.
module scl_phase_ctrl
    import scl_gen_pkg::*;
#(
    parameter int PH_W = 16,
    parameter int RT_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            scl_sense,
    input  logic [PH_W-1:0] low_len,
    input  logic [PH_W-1:0] high_len,
    input  logic [PH_W-1:0] half_high,
    input  logic [RT_W-1:0] rise_lim,
    output logic            pull_low,
    output logic            strobe_mid,
    output logic            strobe_fall
);
    scl_phase_t      phase_q;
    logic [PH_W-1:0] cnt_q;
    logic [RT_W-1:0] wait_q;
    logic            started_q;
    logic            fall_q;

    logic in_high;
    logic go;
    logic last_low;
    logic last_high;

    // Decide whether the high count advances and where a phase ends.
    always_comb begin
        in_high   = (phase_q == PH_HIGH);
        go        = in_high && (started_q || scl_sense || (wait_q == rise_lim));
        last_low  = (phase_q == PH_LOW) && (cnt_q == low_len - PH_W'(1));
        last_high = go && (cnt_q == high_len - PH_W'(1));
    end

    // Advance the phase, the cycle counter and the rise wait.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            phase_q   <= PH_OFF;
            cnt_q     <= '0;
            wait_q    <= '0;
            started_q <= 1'b0;
            fall_q    <= 1'b0;
        end else begin
            fall_q <= 1'b0;
            case (phase_q)
                PH_OFF: begin
                    phase_q <= PH_LOW;
                    cnt_q   <= '0;
                    fall_q  <= 1'b1;
                end
                PH_LOW: begin
                    if (last_low) begin
                        phase_q   <= PH_HIGH;
                        cnt_q     <= '0;
                        wait_q    <= '0;
                        started_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + PH_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (go) begin
                        started_q <= 1'b1;
                        if (last_high) begin
                            phase_q <= PH_LOW;
                            cnt_q   <= '0;
                            fall_q  <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + PH_W'(1);
                        end
                    end else begin
                        wait_q <= wait_q + RT_W'(1);
                    end
                end
                default: phase_q <= PH_OFF;
            endcase
        end
    end

    // Drive the line request and the strobes.
    always_comb begin
        pull_low    = (phase_q == PH_LOW);
        strobe_fall = fall_q;
        strobe_mid  = go && (cnt_q == half_high);
    end
endmodule

// File: rtl/scl_clkgen.sv
// Top of the SCL clock generator: phase lengths, rise wait clamp and
// the sequencer that drives the line request and strobes.
// Assumes: configuration changes only while en is low.
module scl_clkgen #(
    parameter int CNT_W = 12,
    parameter int RT_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             fast_mode,
    input  logic             duty_169,
    input  logic [CNT_W-1:0] ccr_count,
    input  logic [RT_W-1:0]  rise_limit,
    input  logic             scl_sense,
    output logic             scl_pull_low,
    output logic             strobe_mid_high,
    output logic             strobe_fall
);
    localparam int PH_W = CNT_W + 4;

    logic [PH_W-1:0] low_len;
    logic [PH_W-1:0] high_len;
    logic [PH_W-1:0] half_high;
    logic [RT_W-1:0] rise_lim;

    scl_phase_len #(.CNT_W(CNT_W), .PH_W(PH_W)) u_len (
        .fast_mode (fast_mode),
        .duty_169  (duty_169),
        .ccr_count (ccr_count),
        .low_len   (low_len),
        .high_len  (high_len),
        .half_high (half_high)
    );

    scl_rise_limit #(.RT_W(RT_W)) u_rise (
        .rise_raw (rise_limit),
        .rise_lim (rise_lim)
    );

    scl_phase_ctrl #(.PH_W(PH_W), .RT_W(RT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .scl_sense   (scl_sense),
        .low_len     (low_len),
        .high_len    (high_len),
        .half_high   (half_high),
        .rise_lim    (rise_lim),
        .pull_low    (scl_pull_low),
        .strobe_mid  (strobe_mid_high),
        .strobe_fall (strobe_fall)
    );
endmodule

// File: rtl/scl_clkgen_chk.sv
// Property checker for the SCL clock generator, bound to the top.
module scl_clkgen_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic fast_mode,
    input logic scl_pull_low,
    input logic strobe_mid_high,
    input logic strobe_fall
);
    logic [15:0] low_run_q;

    // Count the cycles of the current low phase, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !scl_pull_low) low_run_q <= '0;
        else if (low_run_q != 16'hFFFF) low_run_q <= low_run_q + 16'd1;
    end

    // R7: disable releases the line and silences the strobes
    a_r7_release_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_pull_low && !strobe_fall && !strobe_mid_high));

    // R8: falling strobe marks every start of a low phase
    a_r8_fall_at_low_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull_low) |-> strobe_fall);

    // R8: falling strobe lasts a single cycle inside the low phase
    a_r8_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_fall |-> scl_pull_low ##1 !strobe_fall);

    // R9: mid strobe only while the line is released
    a_r9_mid_released: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_mid_high |-> !scl_pull_low);

    // R4: a standard-mode low phase never ends before 4 cycles
    a_r4_std_min_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_pull_low) && $past(en) && !$past(fast_mode)) |-> (low_run_q >= 16'd4));
endmodule

bind scl_clkgen scl_clkgen_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .en              (en),
    .fast_mode       (fast_mode),
    .scl_pull_low    (scl_pull_low),
    .strobe_mid_high (strobe_mid_high),
    .strobe_fall     (strobe_fall)
);

// File: tb/test_scl_clkgen.sv
module test_scl_clkgen;
    localparam int CW = 12;
    localparam int RW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          en;
    logic          fast_mode;
    logic          duty_169;
    logic [CW-1:0] ccr_count;
    logic [RW-1:0] rise_limit;
    logic          scl_sense;
    logic          scl_pull_low;
    logic          strobe_mid_high;
    logic          strobe_fall;

    int n_chk  = 0;
    int n_fail = 0;
    int hold_left = 0;
    int stretch   = 0;

    always #10 clk = ~clk;

    scl_clkgen #(.CNT_W(CW), .RT_W(RW)) i_scl_clkgen (
        .clk             (clk),
        .rst_n           (rst_n),
        .en              (en),
        .fast_mode       (fast_mode),
        .duty_169        (duty_169),
        .ccr_count       (ccr_count),
        .rise_limit      (rise_limit),
        .scl_sense       (scl_sense),
        .scl_pull_low    (scl_pull_low),
        .strobe_mid_high (strobe_mid_high),
        .strobe_fall     (strobe_fall)
    );

    // Line model: released line rises after a slave hold of 'stretch' cycles.
    assign scl_sense = !scl_pull_low && (hold_left == 0);
    always @(posedge clk) begin
        if (scl_pull_low) hold_left <= stretch;
        else if (hold_left > 0) hold_left <= hold_left - 1;
    end

    function automatic int eff_n(int c, bit f);
        int m = f ? 1 : 4;
        return (c < m) ? m : c;
    endfunction

    function automatic int exp_low(int c, bit f, bit d);
        int n = eff_n(c, f);
        if (!f) return n;
        return d ? 16 * n : 2 * n;
    endfunction

    function automatic int exp_high(int c, bit f, bit d);
        int n = eff_n(c, f);
        if (!f) return n;
        return d ? 9 * n : n;
    endfunction

    function automatic int exp_wait(int r, int s);
        int w = (r < 2) ? 2 : r;
        return (s < w) ? s : w;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic run_case(input int c, input bit f, input bit d, input int r, input int s);
        int    lo;
        int    hi;
        int    w;
        int    g;
        string mtag;
        string ptag;
        en = 1'b0;
        repeat (3) @(negedge clk);
        fast_mode  = f;
        duty_169   = d;
        ccr_count  = CW'(c);
        rise_limit = RW'(r);
        stretch    = s;
        @(negedge clk);
        en = 1'b1;
        lo = exp_low(c, f, d);
        hi = exp_high(c, f, d);
        w  = exp_wait(r, s);
        mtag = !f ? "R1" : (d ? "R3" : "R2");
        if (c < (f ? 1 : 4)) mtag = "R4";
        ptag = (s > 0) ? ((r < 2 && s >= 2) ? "R5" : "R6") : mtag;
        g = 0;
        while (!strobe_fall && g < 100) begin
            @(negedge clk);
            g++;
        end
        chk(strobe_fall && scl_pull_low, "R8 first fall", int'(strobe_fall), 1);
        for (int p = 0; p < 2; p++) begin
            int idx    = 0;
            int lowc   = 0;
            int midc   = 0;
            int midpos = -1;
            do begin
                if (scl_pull_low) lowc++;
                if (strobe_mid_high) begin
                    midc++;
                    midpos = idx;
                end
                @(negedge clk);
                idx++;
            end while (!strobe_fall && idx < 5000);
            chk(lowc == lo, {mtag, " low length"}, lowc, lo);
            chk(idx == lo + w + hi, {ptag, " period"}, idx, lo + w + hi);
            chk(midc == 1, "R9 mid count", midc, 1);
            chk(midpos == lo + w + hi / 2, "R9 mid position", midpos, lo + w + hi / 2);
        end
        en = 1'b0;
    endtask

    task automatic check_idle(input string req, input int cycles);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (scl_pull_low || strobe_fall || strobe_mid_high) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_up();
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0;
        en = 1'b1;
        fast_mode = 1'b0;
        duty_169 = 1'b0;
        ccr_count = CW'(6);
        rise_limit = RW'(10);
        // R7: reset state holds the line released, even with en high
        check_idle("R7 reset state", 5);
        @(negedge clk);
        rst_n = 1'b1;
        en = 1'b0;
        check_idle("R7 disabled", 20);

        run_case(5, 1'b0, 1'b0, 10, 0);   // R1
        run_case(7, 1'b1, 1'b0, 10, 0);   // R2
        run_case(3, 1'b1, 1'b1, 10, 0);   // R3
        run_case(0, 1'b0, 1'b0, 10, 0);   // R4 std floor
        run_case(3, 1'b0, 1'b0, 10, 0);   // R4 std floor
        run_case(0, 1'b1, 1'b0, 10, 0);   // R4 fast floor, 2:1
        run_case(0, 1'b1, 1'b1, 10, 0);   // R4 fast floor, 16:9
        run_case(6, 1'b0, 1'b0, 0, 6);    // R5 limit 0 -> 2
        run_case(6, 1'b0, 1'b0, 1, 6);    // R5 limit 1 -> 2
        run_case(6, 1'b1, 1'b0, 5, 9);    // R6 wait capped by limit
        run_case(6, 1'b0, 1'b0, 40, 4);   // R6 stretch shorter than limit
        run_case(4, 1'b0, 1'b0, 63, 63);  // R6 limit at its maximum

        // R7: after a run, disable releases the line
        @(negedge clk);
        check_idle("R7 after disable", 20);

        for (int k = 0; k < 24; k++) begin
            int c = int'($urandom_range(0, 30));
            bit f = 1'($urandom_range(0, 1));
            bit d = 1'($urandom_range(0, 1));
            int r = int'($urandom_range(0, 63));
            int s = int'($urandom_range(0, 8));
            run_case(c, f, d, r, s);
        end
        finish_up();
    end
endmodule